// File: doc/BRIEF.md
# Program Memory Byte Load Unit

This unit carries out the three forms of the constant-fetch instruction of an 8-bit microcontroller core. Program memory is organised as 16-bit words, but software addresses it by byte. The unit takes a 16-bit byte pointer, which the register file keeps in the register pair r31 (upper byte) and r30 (lower byte). It turns that pointer into a word address and a byte-lane select. It fetches the word through a synchronous read port and writes the selected byte into a destination register. One form also writes back the pointer plus one.

The surrounding core presents the instruction word and the current pointer value together with a one-cycle start strobe. The core then waits for the done pulse. Each accepted instruction takes exactly three cycles. The first cycle decodes the instruction and captures the pointer. The second cycle drives the memory read. The third cycle selects the byte, writes it back and pulses done. When the post-increment form names r30 or r31 as its destination, the result is architecturally undefined. The unit handles this case in a fixed way: it writes the byte, skips the pointer write and flags the case on a separate output. The unit writes no status flags.

Top module: `pmem_byte_load`

## Requirements
- R1: In the second cycle of an operation `pm_re_o` is high and `pm_addr_o` equals the captured pointer shifted right by one bit. `pm_re_o` is low in every other cycle.
- R2: Pointer bit 0 selects the byte lane of the fetched word. A value of 0 writes bits 7:0 and a value of 1 writes bits 15:8.
- R3: Instruction word 0x95C8 writes the loaded byte to register 0 and asserts no pointer write.
- R4: An instruction whose bits 15:9 are 1001000 and bits 3:0 are 0100 writes the loaded byte to the register numbered by bits 8:4, and asserts no pointer write.
- R5: An instruction whose bits 15:9 are 1001000 and bits 3:0 are 0101 writes the byte to the register numbered by bits 8:4. In the same cycle it asserts `ptr_we_o` with `ptr_wdata_o` equal to the pointer plus one, and the value wraps from 0xFFFF to 0x0000.
- R6: The post-increment form with destination 30 or 31 still writes the byte. It asserts `undef_o` together with done and never asserts `ptr_we_o`.
- R7: `done_o` is a one-cycle pulse in the third cycle, where the start cycle is the first. `rf_we_o` and `ptr_we_o` are only ever high together with `done_o`.
- R8: A start strobe carrying any other instruction word produces no read, no write and no done. A start strobe that arrives during an operation in progress is ignored.
- R9: After reset the unit is idle, with `done_o`, `pm_re_o`, `rf_we_o`, `ptr_we_o` and `undef_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for the instruction on `instr_i` |
| instr_i | input | 16 | Instruction word |
| ptr_i | input | PTR_W (16) | Current pointer value {r31, r30} |
| rf_we_o | output | 1 | Register-file byte write enable |
| rf_waddr_o | output | REG_AW (5) | Destination register number |
| rf_wdata_o | output | BYTE_W (8) | Loaded byte |
| ptr_we_o | output | 1 | Write enable for the pointer pair |
| ptr_wdata_o | output | PTR_W (16) | Incremented pointer value |
| pm_re_o | output | 1 | Program-memory read strobe |
| pm_addr_o | output | ADDR_W (15) | Program-memory word address |
| pm_rdata_i | input | WORD_W (16) | Word read data, valid the cycle after `pm_re_o` |
| done_o | output | 1 | Completion pulse |
| undef_o | output | 1 | Undefined destination case, valid with `done_o` |

## Verification
The assertions assume a memory with exactly one cycle of read latency. They also assume that `ptr_i` carries the pointer in the cycle where the start strobe is accepted, because the post-increment check compares the written pointer with the pointer input from two cycles earlier. The bench models the memory as a register that loads a computed word on every read strobe. It presents each pointer together with its start strobe. It also includes strobes that arrive during a busy operation and strobes with unrelated instruction words, so that the ignore rules are exercised without violating the latency assumption.

// File: rtl/pml_pkg.sv
package pml_pkg;

    localparam int INSTR_W = 16;
    localparam int DST_W   = 5;

    localparam logic [INSTR_W-1:0] ENC_IMPLIED   = 16'h95C8;
    localparam logic [6:0]         ENC_HI_MATCH  = 7'b1001000;
    localparam logic [3:0]         ENC_LO_PLAIN  = 4'b0100;
    localparam logic [3:0]         ENC_LO_INCR   = 4'b0101;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_IMPLIED,
        OP_PLAIN,
        OP_POSTINC
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WB
    } st_e;

    typedef struct packed {
        op_e              op;
        logic [DST_W-1:0] dst;
        logic             incr;
        logic             undef;
    } dec_t;

    // A destination is a pointer half when all but its lowest bit are set.
    function automatic logic is_ptr_reg(input logic [DST_W-1:0] d);
        return &d[DST_W-1:1];
    endfunction

endpackage

// File: rtl/pml_decode.sv
module pml_decode
    import pml_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    always_comb begin
        dec = '0;
        if (instr == ENC_IMPLIED) begin
            dec.op  = OP_IMPLIED;
            dec.dst = '0;
        end else if (instr[15:9] == ENC_HI_MATCH && instr[3:0] == ENC_LO_PLAIN) begin
            dec.op  = OP_PLAIN;
            dec.dst = instr[8:4];
        end else if (instr[15:9] == ENC_HI_MATCH && instr[3:0] == ENC_LO_INCR) begin
            dec.op    = OP_POSTINC;
            dec.dst   = instr[8:4];
            dec.incr  = 1'b1;
            dec.undef = is_ptr_reg(instr[8:4]);
        end
    end
endmodule

// File: rtl/pml_lane_sel.sv
module pml_lane_sel #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lane [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = word[i*BYTE_W +: BYTE_W];
    end

    assign byte_o = lane[sel];
endmodule

// File: rtl/pml_ptr_inc.sv
module pml_ptr_inc #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    assign nxt = cur + ONE;
endmodule

// File: rtl/pmem_byte_load.sv
module pmem_byte_load
    import pml_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int REG_AW = 5,
    parameter int ADDR_W = PTR_W - $clog2(WORD_W / BYTE_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [15:0]         instr_i,
    input  logic [PTR_W-1:0]    ptr_i,
    output logic                rf_we_o,
    output logic [REG_AW-1:0]   rf_waddr_o,
    output logic [BYTE_W-1:0]   rf_wdata_o,
    output logic                ptr_we_o,
    output logic [PTR_W-1:0]    ptr_wdata_o,
    output logic                pm_re_o,
    output logic [ADDR_W-1:0]   pm_addr_o,
    input  logic [WORD_W-1:0]   pm_rdata_i,
    output logic                done_o,
    output logic                undef_o
);
    localparam int SEL_W = $clog2(WORD_W / BYTE_W);

    st_e              st_q;
    dec_t             dec_d;
    dec_t             op_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_nxt;
    logic [BYTE_W-1:0] byte_sel;
    logic             in_wb;

    pml_decode u_dec (
        .instr (instr_i),
        .dec   (dec_d)
    );

    pml_lane_sel #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lane (
        .word   (pm_rdata_i),
        .sel    (ptr_q[SEL_W-1:0]),
        .byte_o (byte_sel)
    );

    pml_ptr_inc #(.W(PTR_W)) u_inc (
        .cur (ptr_q),
        .nxt (ptr_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            op_q  <= '0;
            ptr_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i && dec_d.op != OP_NONE) begin
                        st_q  <= ST_FETCH;
                        op_q  <= dec_d;
                        ptr_q <= ptr_i;
                    end
                end
                ST_FETCH: st_q <= ST_WB;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    assign in_wb       = (st_q == ST_WB);
    assign pm_re_o     = (st_q == ST_FETCH);
    assign pm_addr_o   = ptr_q[PTR_W-1:SEL_W];
    assign done_o      = in_wb;
    assign rf_we_o     = in_wb && op_q.op != OP_NONE;
    assign rf_waddr_o  = REG_AW'(op_q.dst);
    assign rf_wdata_o  = byte_sel;
    assign ptr_we_o    = in_wb && op_q.incr && !op_q.undef;
    assign ptr_wdata_o = ptr_nxt;
    assign undef_o     = in_wb && op_q.undef;

    // R7: completion follows a read strobe by one cycle
    p_done_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(pm_re_o));
    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R7: writes only with completion
    p_write_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o || ptr_we_o) |-> done_o);
    // R8: a read only starts from an accepted strobe
    p_read_needs_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pm_re_o) |-> $past(start_i));
    // R6: undefined case never writes the pointer
    p_no_ptr_write_undef_r6: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (!ptr_we_o && rf_we_o));
    // R5: written pointer is the start-cycle pointer plus one
    p_inc_value_r5: assert property (@(posedge clk) disable iff (rst)
        ptr_we_o |-> ptr_wdata_o == $past(ptr_i, 2) + PTR_W'(1));
    // R1: read address stays put while the read is outstanding
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $stable(pm_addr_o));
endmodule

// File: tb/pmem_byte_load_tb.sv
module pmem_byte_load_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [15:0] instr_i;
    logic [15:0] ptr_i;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [7:0]  rf_wdata_o;
    logic        ptr_we_o;
    logic [15:0] ptr_wdata_o;
    logic        pm_re_o;
    logic [14:0] pm_addr_o;
    logic [15:0] pm_rdata_i;
    logic        done_o;
    logic        undef_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pmem_byte_load u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i), .ptr_i(ptr_i),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .ptr_we_o(ptr_we_o), .ptr_wdata_o(ptr_wdata_o), .pm_re_o(pm_re_o),
        .pm_addr_o(pm_addr_o), .pm_rdata_i(pm_rdata_i), .done_o(done_o),
        .undef_o(undef_o)
    );

    function automatic logic [15:0] mem_word(input logic [14:0] a);
        return {a[7:0] ^ 8'h3C, a[14:7] ^ 8'h5A};
    endfunction

    always @(posedge clk) begin
        if (pm_re_o) pm_rdata_i <= mem_word(pm_addr_o);
    end

    typedef struct packed {
        logic [15:0] instr;
        logic [15:0] ptr;
        logic [4:0]  dst;
        logic        pwe;
        logic        undef;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'h95C8, 16'h1234, 5'd0,  1'b0, 1'b0},   // R3 low lane
        '{16'h95C8, 16'h1235, 5'd0,  1'b0, 1'b0},   // R3 high lane
        '{16'h9104, 16'h0000, 5'd16, 1'b0, 1'b0},   // R4
        '{16'h91F4, 16'hFFFF, 5'd31, 1'b0, 1'b0},   // R4 no increment into r31
        '{16'h9055, 16'h00FF, 5'd5,  1'b1, 1'b0},   // R5
        '{16'h9115, 16'hFFFF, 5'd17, 1'b1, 1'b0},   // R5 wrap
        '{16'h91E5, 16'h8000, 5'd30, 1'b0, 1'b1},   // R6
        '{16'h91F5, 16'h4001, 5'd31, 1'b0, 1'b1},   // R6
        '{16'h9005, 16'h7FFE, 5'd0,  1'b1, 1'b0}    // R5
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v);
        logic [15:0] w;
        logic [7:0]  b;
        w = mem_word(v.ptr[15:1]);
        b = v.ptr[0] ? w[15:8] : w[7:0];
        @(negedge clk);
        start_i = 1'b1; instr_i = v.instr; ptr_i = v.ptr;
        @(negedge clk);
        start_i = 1'b0; instr_i = 16'h0000;
        chk("R1", "pm_re", {31'd0, pm_re_o}, 32'd1);
        chk("R1", "pm_addr", {17'd0, pm_addr_o}, {17'd0, v.ptr[15:1]});
        chk("R7", "early done", {31'd0, done_o}, 32'd0);
        @(negedge clk);
        chk("R7", "done", {31'd0, done_o}, 32'd1);
        chk("R2", "rf_we", {31'd0, rf_we_o}, 32'd1);
        chk("R4", "dst", {27'd0, rf_waddr_o}, {27'd0, v.dst});
        chk("R2", "byte", {24'd0, rf_wdata_o}, {24'd0, b});
        chk("R5", "ptr_we", {31'd0, ptr_we_o}, {31'd0, v.pwe});
        if (v.pwe) chk("R5", "ptr_wdata", {16'd0, ptr_wdata_o}, {16'd0, v.ptr + 16'd1});
        chk("R6", "undef", {31'd0, undef_o}, {31'd0, v.undef});
        chk("R1", "pm_re off", {31'd0, pm_re_o}, 32'd0);
        @(negedge clk);
        chk("R7", "done pulse", {31'd0, done_o}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; instr_i = '0; ptr_i = '0; pm_rdata_i = '0;
        repeat (3) @(negedge clk);
        chk("R9", "reset strobes",
            {27'd0, done_o, pm_re_o, rf_we_o, ptr_we_o, undef_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "idle strobes",
            {27'd0, done_o, pm_re_o, rf_we_o, ptr_we_o, undef_o}, 32'd0);

        for (int i = 0; i < NV; i++) run_op(VECS[i]);

        // R8: unrelated instruction words are ignored
        @(negedge clk);
        start_i = 1'b1; instr_i = 16'h9006; ptr_i = 16'h0042;
        @(negedge clk);
        instr_i = 16'h95C9;
        @(negedge clk);
        instr_i = 16'h9404;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8", "ignored read", {31'd0, pm_re_o}, 32'd0);
        chk("R8", "ignored done", {30'd0, done_o, rf_we_o}, 32'd0);
        @(negedge clk);
        chk("R8", "ignored late done", {30'd0, done_o, rf_we_o}, 32'd0);

        // R8: strobe while busy is ignored
        @(negedge clk);
        start_i = 1'b1; instr_i = 16'h9104; ptr_i = 16'h0203;
        @(negedge clk);
        instr_i = 16'h9055; ptr_i = 16'h0500;
        @(negedge clk);
        chk("R8", "busy dst", {27'd0, rf_waddr_o}, 32'd16);
        chk("R8", "busy no ptr write", {31'd0, ptr_we_o}, 32'd0);
        start_i = 1'b0;
        @(negedge clk);
        chk("R8", "busy no new read", {31'd0, pm_re_o}, 32'd0);

        // R9: reset in the middle of an operation
        @(negedge clk);
        start_i = 1'b1; instr_i = 16'h95C8; ptr_i = 16'h0010;
        @(negedge clk);
        start_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "abort", {30'd0, done_o, pm_re_o}, 32'd0);
        @(negedge clk);
        chk("R9", "abort idle", {30'd0, done_o, pm_re_o}, 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule